// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit nanosecond time of day for precision time protocols. On every cycle of its clock, while it is enabled, the raw count advances by a programmable period. The period is a fixed-point value: an integer number of nanoseconds plus a 32-bit binary fraction. The fraction feeds an accumulator, and each carry out of that accumulator adds one extra nanosecond. A separate signed 64-bit offset is added to the raw count to form the reported time. Software adjusts phase by changing this offset, so the running counter is never rewritten.

Software uses a plain 32-bit register port with an address, write data, a write strobe, a read strobe and read data. A 64-bit value is written as two words, low word first. The low word waits in a shadow register, and the write of the high word commits both halves on one edge. Reading the low word of the current time freezes the matching high half, so a following high-word read stays coherent while the counter runs. The register port has no back-pressure: every strobe is accepted in the cycle it is presented, and read data appears on the next cycle. The current time is also driven out on a plain 64-bit status output.

Top module: `frac_tod_timer`

## Requirements
- R1: After reset the control word reads 0, the fraction reads 0, the prescaler reads 2, the offset reads 0, and the current time is 0.
- R2: The control word at address 0x00 holds the following fields: enable at bit 0, a stored reference-source select at bits 2:1, the deferred-period flag at bit 3, and the integer period at bits 25:16. All other bits read back as 0.
- R3: On each cycle with enable set, the 32-bit fraction (address 0x04) is added to a 32-bit accumulator. The raw count then grows by the active integer period plus the carry out of that addition.
- R4: While enable is clear, the raw count and the accumulator hold their values. Register writes are still accepted.
- R5: When a control write has the deferred flag set, its integer period is stored but does not take effect. It becomes active on the edge that writes the fraction register.
- R6: When a control write has the deferred flag clear, its integer period becomes active on the same edge, and it is used from the next cycle on.
- R7: A write to the counter low word (0x10) changes nothing that is visible. A write to the counter high word (0x14) loads {high, stored low} into the raw count on that edge and clears the accumulator. A load takes priority over an increment in the same cycle.
- R8: The offset is written as a low word (0x18) and then a high word (0x1C), with the same shadowing. Reads of 0x18 and 0x1C return the committed offset.
- R9: The current time equals the raw count plus the offset, modulo 2^64. The offset is treated as a two's-complement value.
- R10: A read of the current-time low word (0x20) returns bits 31:0 of the time and captures bits 63:32. A later read of 0x24 returns that captured half. Read data is valid on the cycle after the read strobe.
- R11: The prescaler at 0x08 is 8-bit read/write storage and resets to 2. Reads of the counter load words and of unmapped addresses return 0.
- R12: The raw count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, accepted in the cycle it is presented |
| reg_re | input | 1 | Read strobe, accepted in the cycle it is presented |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| time_now | output | 64 | Current time: raw count plus offset |

## Verification
The bench builds the block with its default parameters. These are a 10-bit integer period, a 32-bit fraction and an 8-bit prescaler. With them the bench can reach the full integer field, exact carry sequences from a quarter-step fraction, and the 64-bit wrap, which it reaches by loading the counter close to the top of its range. Loading the counter just below a 32-bit boundary, with the timer running, lets the bench show that the captured high half stays coherent after the live time has crossed that boundary.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // Register word addresses
  localparam int unsigned A_CTRL   = 'h00;
  localparam int unsigned A_FRAC   = 'h04;
  localparam int unsigned A_PRSC   = 'h08;
  localparam int unsigned A_CNT_LO = 'h10;
  localparam int unsigned A_CNT_HI = 'h14;
  localparam int unsigned A_OFS_LO = 'h18;
  localparam int unsigned A_OFS_HI = 'h1C;
  localparam int unsigned A_NOW_LO = 'h20;
  localparam int unsigned A_NOW_HI = 'h24;

  // Control word fields
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned SRC_LSB   = 1;
  localparam int unsigned SRC_W     = 2;
  localparam int unsigned DEFER_BIT = 3;
  localparam int unsigned INT_LSB   = 16;

  function automatic bit is_readable(input int unsigned a);
    return (a == A_CTRL) || (a == A_FRAC) || (a == A_PRSC) ||
           (a == A_OFS_LO) || (a == A_OFS_HI) ||
           (a == A_NOW_LO) || (a == A_NOW_HI);
  endfunction
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned INT_W    = 10,
  parameter int unsigned PRSC_W   = 8,
  parameter int unsigned PRSC_RST = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  en,
  output logic [SRC_W-1:0]      src,
  output logic                  defer,
  output logic [INT_W-1:0]      int_cfg,
  output logic [INT_W-1:0]      int_live,
  output logic [DATA_W-1:0]     frac,
  output logic [PRSC_W-1:0]     prsc,
  output logic [2*DATA_W-1:0]   ofs,
  output logic                  cnt_ld,
  output logic [2*DATA_W-1:0]   cnt_ld_val
);
  logic [DATA_W-1:0] cnt_lo_sh;
  logic [DATA_W-1:0] ofs_lo_sh;

  logic wr_ctrl, wr_frac, wr_prsc, wr_clo, wr_chi, wr_olo, wr_ohi;
  assign wr_ctrl = we && (addr == ADDR_W'(A_CTRL));
  assign wr_frac = we && (addr == ADDR_W'(A_FRAC));
  assign wr_prsc = we && (addr == ADDR_W'(A_PRSC));
  assign wr_clo  = we && (addr == ADDR_W'(A_CNT_LO));
  assign wr_chi  = we && (addr == ADDR_W'(A_CNT_HI));
  assign wr_olo  = we && (addr == ADDR_W'(A_OFS_LO));
  assign wr_ohi  = we && (addr == ADDR_W'(A_OFS_HI));

  // Counter load commits on the high-word write, same edge
  assign cnt_ld     = wr_chi;
  assign cnt_ld_val = {wdata, cnt_lo_sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      src       <= '0;
      defer     <= 1'b0;
      int_cfg   <= '0;
      int_live  <= '0;
      frac      <= '0;
      prsc      <= PRSC_W'(PRSC_RST);
      cnt_lo_sh <= '0;
      ofs_lo_sh <= '0;
      ofs       <= '0;
    end else begin
      if (wr_ctrl) begin
        en      <= wdata[EN_BIT];
        src     <= wdata[SRC_LSB +: SRC_W];
        defer   <= wdata[DEFER_BIT];
        int_cfg <= wdata[INT_LSB +: INT_W];
        if (!wdata[DEFER_BIT]) int_live <= wdata[INT_LSB +: INT_W];
      end
      if (wr_frac) begin
        frac     <= wdata;
        int_live <= int_cfg;   // integer and fraction switch together
      end
      if (wr_prsc) prsc      <= wdata[PRSC_W-1:0];
      if (wr_clo)  cnt_lo_sh <= wdata;
      if (wr_olo)  ofs_lo_sh <= wdata;
      if (wr_ohi)  ofs       <= {wdata, ofs_lo_sh};
    end
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned INT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  int_live,
  input  logic [FRAC_W-1:0] frac,
  input  logic              ld,
  input  logic [CNT_W-1:0]  ld_val,
  output logic [CNT_W-1:0]  cnt
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   fsum;

  assign fsum = {1'b0, acc} + {1'b0, frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (ld) begin
      cnt <= ld_val;
      acc <= '0;
    end else if (en) begin
      acc <= fsum[FRAC_W-1:0];
      cnt <= cnt + CNT_W'(int_live) + CNT_W'(fsum[FRAC_W]);
    end
  end
endmodule

// File: rtl/tod_readout.sv
module tod_readout
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                re,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*DATA_W-1:0] now,
  input  logic [DATA_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0]   frac,
  input  logic [DATA_W-1:0]   prsc_word,
  input  logic [2*DATA_W-1:0] ofs,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] snap_hi;
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    if      (addr == ADDR_W'(A_CTRL))   word = ctrl_word;
    else if (addr == ADDR_W'(A_FRAC))   word = frac;
    else if (addr == ADDR_W'(A_PRSC))   word = prsc_word;
    else if (addr == ADDR_W'(A_OFS_LO)) word = ofs[DATA_W-1:0];
    else if (addr == ADDR_W'(A_OFS_HI)) word = ofs[2*DATA_W-1:DATA_W];
    else if (addr == ADDR_W'(A_NOW_LO)) word = now[DATA_W-1:0];
    else if (addr == ADDR_W'(A_NOW_HI)) word = snap_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      snap_hi <= '0;
    end else if (re) begin
      rdata <= word;
      if (addr == ADDR_W'(A_NOW_LO)) snap_hi <= now[2*DATA_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/frac_tod_timer.sv
module frac_tod_timer
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned INT_W    = 10,
  parameter int unsigned PRSC_W   = 8,
  parameter int unsigned PRSC_RST = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_we,
  input  logic                  reg_re,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [2*DATA_W-1:0]   time_now
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic              en, defer, cnt_ld;
  logic [SRC_W-1:0]  src;
  logic [INT_W-1:0]  int_cfg, int_live;
  logic [DATA_W-1:0] frac;
  logic [PRSC_W-1:0] prsc;
  logic [CNT_W-1:0]  ofs, cnt_ld_val, cnt_raw;
  logic [DATA_W-1:0] ctrl_word, prsc_word;

  tod_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INT_W(INT_W),
    .PRSC_W(PRSC_W), .PRSC_RST(PRSC_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en(en), .src(src), .defer(defer), .int_cfg(int_cfg), .int_live(int_live),
    .frac(frac), .prsc(prsc), .ofs(ofs), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val)
  );

  tod_accum #(.CNT_W(CNT_W), .FRAC_W(DATA_W), .INT_W(INT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(en), .int_live(int_live), .frac(frac),
    .ld(cnt_ld), .ld_val(cnt_ld_val), .cnt(cnt_raw)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_BIT]            = en;
    ctrl_word[SRC_LSB +: SRC_W]  = src;
    ctrl_word[DEFER_BIT]         = defer;
    ctrl_word[INT_LSB +: INT_W]  = int_cfg;
    prsc_word = DATA_W'(prsc);
  end

  assign time_now = cnt_raw + ofs;  // modulo 2^64, offset two's complement

  tod_readout #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_read (
    .clk(clk), .rst_n(rst_n), .re(reg_re), .addr(reg_addr), .now(time_now),
    .ctrl_word(ctrl_word), .frac(frac), .prsc_word(prsc_word), .ofs(ofs),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned INT_W  = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic                reg_we,
  input logic                reg_re,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [2*DATA_W-1:0] time_now,
  input logic [2*DATA_W-1:0] cnt,
  input logic [2*DATA_W-1:0] ld_val,
  input logic [INT_W-1:0]    int_live,
  input logic                en
);
  localparam int unsigned CW = 2 * DATA_W;

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && !reg_we |=> (cnt == $past(cnt) + CW'($past(int_live))) ||
                      (cnt == $past(cnt) + CW'($past(int_live)) + CW'(1))); // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !reg_we |=> $stable(time_now)); // R4
  AST_DEFER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[DEFER_BIT] |=> int_live == $past(int_live)); // R5
  AST_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == ADDR_W'(A_CNT_LO) && !en |=> $stable(time_now)); // R7
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == ADDR_W'(A_CNT_HI) |=> cnt == $past(ld_val)); // R7
  AST_SNAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && reg_addr == ADDR_W'(A_NOW_LO) |=> reg_rdata == $past(time_now[DATA_W-1:0])); // R10
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && !is_readable(int'(reg_addr)) |=> reg_rdata == '0); // R11
endmodule

bind frac_tod_timer tod_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .time_now(time_now),
  .cnt(cnt_raw), .ld_val(cnt_ld_val), .int_live(int_live), .en(en)
);

// File: tb/test_frac_tod_timer.sv
module test_frac_tod_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  frac_tod_timer i_frac_tod_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .time_now(time_now)
  );

  function automatic logic [31:0] mk(input bit e, input int s, input bit d, input int p);
    logic [31:0] w = '0;
    w[0] = e; w[2:1] = s[1:0]; w[3] = d; w[25:16] = p[9:0];
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    reg_addr = a[7:0]; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = a[7:0]; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cnt(input logic [63:0] v);
    wr('h10, v[31:0]); wr('h14, v[63:32]);
  endtask

  task automatic load_ofs(input logic [63:0] v);
    wr('h18, v[31:0]); wr('h1C, v[63:32]);
  endtask

  // exactly n enabled cycles
  task automatic run(input int n, input bit d, input int p);
    wr('h00, mk(1, 0, d, p));
    idle(n - 1);
    wr('h00, mk(0, 0, d, p));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 time", time_now, 64'd0);
    rd('h00, d); chk("R1 ctrl", 64'(d), 64'd0);
    rd('h04, d); chk("R1 frac", 64'(d), 64'd0);
    rd('h08, d); chk("R1 prescaler", 64'(d), 64'd2);
    rd('h1C, d); chk("R1 offset hi", 64'(d), 64'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr('h00, mk(0, 2, 0, 'h155));
    rd('h00, d); chk("R2 ctrl fields", 64'(d), 64'(mk(0, 2, 0, 'h155)));
    wr('h00, 32'hFFFF_FFF0);
    rd('h00, d); chk("R2 unused bits", 64'(d), 64'h03FF_0000);
    wr('h08, 32'h0000_01A5);
    rd('h08, d); chk("R11 prescaler", 64'(d), 64'hA5);
    rd('h40, d); chk("R11 unmapped", 64'(d), 64'd0);
    rd('h10, d); chk("R11 count word", 64'(d), 64'd0);
    wr('h00, 32'd0);
  endtask

  task automatic t_int;
    wr('h00, mk(0, 0, 0, 8));
    wr('h04, 32'd0);
    load_cnt(64'd1000);
    run(5, 0, 8);
    chk("R3 R6 integer steps", time_now, 64'd1040);
  endtask

  task automatic t_hold;
    logic [63:0] t = time_now;
    idle(5);
    chk("R4 hold idle", time_now, t);
    wr('h04, 32'h8000_0000);
    idle(2);
    chk("R4 hold after write", time_now, t);
  endtask

  task automatic t_frac;
    wr('h00, mk(0, 0, 0, 3));
    load_cnt(64'd0);               // also clears accumulator (R7)
    wr('h04, 32'h4000_0000);       // 0.25 ns
    run(8, 0, 3);
    chk("R3 carries over 8", time_now, 64'd26);
    run(3, 0, 3);
    chk("R3 no carry over 3", time_now, 64'd35);
    run(1, 0, 3);
    chk("R3 single carry", time_now, 64'd39);
  endtask

  task automatic t_defer;
    logic [31:0] d;
    wr('h00, mk(0, 0, 0, 5));
    wr('h04, 32'd0);
    load_cnt(64'd0);
    wr('h00, mk(0, 0, 1, 7));
    run(4, 1, 7);
    chk("R5 old period kept", time_now, 64'd20);
    rd('h00, d); chk("R5 stored field", 64'(d), 64'(mk(0, 0, 1, 7)));
    wr('h04, 32'd0);
    run(2, 1, 7);
    chk("R5 period after fraction write", time_now, 64'd34);
  endtask

  task automatic t_load_ofs;
    logic [31:0] d;
    logic [63:0] neg = -64'sd1000;
    wr('h10, 32'hDEAD_BEEF);
    idle(2);
    chk("R7 low word invisible", time_now, 64'd34);
    wr('h14, 32'h12);
    chk("R7 commit", time_now, 64'h12_DEAD_BEEF);
    wr('h18, neg[31:0]);
    chk("R8 offset low invisible", time_now, 64'h12_DEAD_BEEF);
    wr('h1C, neg[63:32]);
    chk("R9 negative offset", time_now, 64'h12_DEAD_BEEF - 64'd1000);
    rd('h18, d); chk("R8 offset lo read", 64'(d), 64'hFFFF_FC18);
    rd('h1C, d); chk("R8 offset hi read", 64'(d), 64'hFFFF_FFFF);
    load_cnt(64'd1);
    load_ofs(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 sum wraps", time_now, 64'd0);
    load_ofs(64'd0);
  endtask

  task automatic t_wrap;
    wr('h00, mk(0, 0, 0, 3));
    wr('h04, 32'd0);
    load_cnt(64'hFFFF_FFFF_FFFF_FFFE);
    run(1, 0, 3);
    chk("R12 wrap", time_now, 64'd1);
  endtask

  task automatic t_snap;
    logic [31:0] lo, hi;
    wr('h00, mk(0, 0, 0, 4));
    load_cnt(64'h2_FFFF_FFF0);
    wr('h00, mk(1, 0, 0, 4));
    rd('h20, lo);
    chk("R10 low word", 64'(lo), 64'hFFFF_FFF0);
    idle(8);
    chk("R10 live time crossed", 64'(time_now[63:32]), 64'd3);
    rd('h24, hi);
    chk("R10 coherent high", 64'(hi), 64'd2);
    wr('h00, 32'd0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_int;
    t_hold;
    t_frac;
    t_defer;
    t_load_ofs;
    t_wrap;
    t_snap;
    done = 1;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
    end
  end
endmodule